// File: doc/BRIEF.md
# Separate-Sync Video to Packet Stream Converter

This block sits on a pixel clock behind a video receiver that delivers picture samples with separate timing strobes. The strobes are an active-picture qualifier, a horizontal sync, a vertical sync, a field-1 flag and a lock indicator. The block re-times the active samples into a packet stream. Each field becomes one packet, with a start marker on its first sample and an end marker on its last sample.

Alongside the stream path, a small meter measures the incoming picture. It records samples per line, lines per field and whether the source is interlaced. It raises a maskable interrupt when that picture shape changes or when lock comes or goes. The meter runs whether or not the stream output is turned on. Software uses a four-word register port to start and stop the output, read the measured format, and acknowledge the sticky flags.

The lock input gates every other video input. When lock drops, any packet in flight is closed at once and the truncation is recorded. Start and stop requests take effect only on packet boundaries, so a register write never produces a partial packet.

Top module: `sync_video_framer`

## Requirements
- R1: After reset the stream outputs and `irq` are low, and all four registers read zero while lock is low. The registers are control at address 0, status at address 1, width at address 2 and height at address 3.
- R2: While control bit 0 (run) is 0, no stream sample is emitted, but the width and height registers still follow the input.
- R3: Setting run in the middle of a field emits nothing for that field. The first packet begins with the first active sample after the next vertical sync.
- R4: Clearing run in the middle of a packet lets that packet finish normally, with all its samples and its end marker. The following field is not emitted.
- R5: A sample is active when lock, the active qualifier and not-vertical-sync all hold. Each active sample of a running field appears once, in order, with its data unchanged. `strmSop` marks the first sample of the field and `strmEop` marks the last one before the next vertical sync; a one-sample field carries both.
- R6: While lock is 0, the video inputs have no effect: nothing is emitted after the closing sample, and the width, height and interlace results hold.
- R7: If lock falls while a packet is open, the held last sample is emitted with `strmEop` one cycle after the first unlocked cycle. Status bit 1 (truncated) then sets and stays set until 1 is written to it.
- R8: A field counts as complete only if it started with a locked vertical sync. Width counts the active samples of the last line, and height counts the lines that held active samples. Both registers update only when two consecutive complete fields agree.
- R9: Status bit 0 (format changed) sets when a published width, height or interlace value changes, and when lock rises or falls. Writing 1 to it clears it. `irq` is that bit ANDed with control bit 1 (mask).
- R10: Status bit 2 (interlaced) reads 1 once the field flag has been seen high in either of the last two complete fields, with the same two-field agreement as R8. Status bit 3 mirrors lock and bit 4 shows an open packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| lockIn | input | 1 | Source locked; gates all video inputs |
| activeIn | input | 1 | Sample belongs to the active picture |
| hSyncIn | input | 1 | Horizontal sync period |
| vSyncIn | input | 1 | Vertical sync period |
| fieldIn | input | 1 | Interlaced and in field 1 |
| pixIn | input | DATA_W | Pixel sample |
| regAddr | input | 2 | Register select |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 2 | Register write data (control and status bits) |
| regRdData | output | 16 | Register read data, combinational on regAddr |
| strmValid | output | 1 | Stream sample valid |
| strmSop | output | 1 | First sample of a packet |
| strmEop | output | 1 | Last sample of a packet |
| strmData | output | DATA_W | Stream sample |
| irq | output | 1 | Masked format-change interrupt |

## Verification
The bench sweeps every field shape from 1x1 to 4x3. A one-sample field needs both markers on a single beat; an off-by-one in the one-sample hold would split or drop that beat, or shorten every packet by one. Run is toggled in the middle of fields: a design that samples run directly rather than at packet start would emit a headless packet or cut one short. Lock is dropped mid-line, and the bench checks the exact cycle of the closing marker, the truncated flag, and that unlocked traffic moves neither the stream nor the meter. Interlace is entered and left to check that the meter needs two agreeing fields rather than reacting to a single field.

// File: rtl/vs_pkg.sv
package vs_pkg;
  localparam int REG_W = 16;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_WID  = 2'd2;
  localparam logic [1:0] ADDR_HGT  = 2'd3;

  typedef struct packed {
    logic load;     // capture pixIn into the hold stage
    logic loadSop;  // captured sample opens a packet
    logic emit;     // push the held sample to the output
    logic emitEop;  // pushed sample closes the packet
  } strobe_t;
endpackage

// File: rtl/vs_fmt.sv
module vs_fmt #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lockIn,
  input  logic             activeIn,
  input  logic             hSyncIn,
  input  logic             vSyncIn,
  input  logic             fieldIn,
  output logic [CNT_W-1:0] pubW,
  output logic [CNT_W-1:0] pubH,
  output logic             pubI,
  output logic             changed
);
  logic hsPrev, vsPrev, fieldGood, candOk, f1Seen, lastF1, candI;
  logic [CNT_W-1:0] sampCnt, lineW, lineCnt, candW, candH;
  logic act, hsRise, vsRise, pendLine, newI;
  logic [CNT_W-1:0] newW, newH;

  assign act      = lockIn & activeIn & ~vSyncIn;
  assign hsRise   = lockIn & hSyncIn & ~hsPrev;
  assign vsRise   = lockIn & vSyncIn & ~vsPrev;
  assign pendLine = (sampCnt != '0);
  assign newW     = pendLine ? sampCnt : lineW;
  assign newH     = lineCnt + CNT_W'(pendLine);
  assign newI     = f1Seen | lastF1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsPrev <= 1'b0; vsPrev <= 1'b0; fieldGood <= 1'b0; candOk <= 1'b0;
      f1Seen <= 1'b0; lastF1 <= 1'b0; candI <= 1'b0; pubI <= 1'b0;
      sampCnt <= '0; lineW <= '0; lineCnt <= '0; candW <= '0; candH <= '0;
      pubW <= '0; pubH <= '0; changed <= 1'b0;
    end else begin
      hsPrev  <= lockIn & hSyncIn;
      vsPrev  <= lockIn & vSyncIn;
      changed <= 1'b0;
      if (!lockIn) begin
        fieldGood <= 1'b0; candOk <= 1'b0; f1Seen <= 1'b0; lastF1 <= 1'b0;
        sampCnt <= '0; lineCnt <= '0;
      end else begin
        if (act) sampCnt <= sampCnt + CNT_W'(1);
        if (fieldIn) f1Seen <= 1'b1;
        if (hsRise && pendLine) begin
          lineW   <= sampCnt;
          lineCnt <= lineCnt + CNT_W'(1);
          sampCnt <= '0;
        end
        if (vsRise) begin
          fieldGood <= 1'b1;
          lineCnt   <= '0;
          sampCnt   <= '0;
          f1Seen    <= fieldIn;
          lastF1    <= f1Seen;
          if (fieldGood) begin
            candW <= newW; candH <= newH; candI <= newI; candOk <= 1'b1;
            if (candOk && candW == newW && candH == newH && candI == newI &&
                (pubW != newW || pubH != newH || pubI != newI)) begin
              pubW <= newW; pubH <= newH; pubI <= newI;
              changed <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/vs_ctrl.sv
module vs_ctrl
  import vs_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lockIn,
  input  logic             activeIn,
  input  logic             vSyncIn,
  input  logic [1:0]       regAddr,
  input  logic             regWrEn,
  input  logic [1:0]       regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic [CNT_W-1:0] fmtW,
  input  logic [CNT_W-1:0] fmtH,
  input  logic             fmtI,
  input  logic             fmtChanged,
  output strobe_t          strobe,
  output logic             frameOpen,
  output logic             fmtFlag,
  output logic             irq
);
  logic lockPrev, vsPrev, armed, runBit, maskBit, truncFlag;
  logic newSample, vsRise, lockFall, lockRise, startFrame, closeFrame, wrCtrl, wrStat;

  assign newSample  = lockIn & activeIn & ~vSyncIn;
  assign vsRise     = lockIn & vSyncIn & ~vsPrev;
  assign lockFall   = lockPrev & ~lockIn;
  assign lockRise   = ~lockPrev & lockIn;
  assign startFrame = armed & newSample & runBit;
  assign closeFrame = frameOpen & (vsRise | lockFall);
  assign wrCtrl     = regWrEn && regAddr == ADDR_CTRL;
  assign wrStat     = regWrEn && regAddr == ADDR_STAT;

  assign strobe.load    = newSample & (frameOpen | startFrame);
  assign strobe.loadSop = startFrame;
  assign strobe.emit    = frameOpen & (newSample | closeFrame);
  assign strobe.emitEop = closeFrame;
  assign irq            = fmtFlag & maskBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockPrev <= 1'b0; vsPrev <= 1'b0; armed <= 1'b0; frameOpen <= 1'b0;
      runBit <= 1'b0; maskBit <= 1'b0; fmtFlag <= 1'b0; truncFlag <= 1'b0;
    end else begin
      lockPrev <= lockIn;
      vsPrev   <= lockIn & vSyncIn;
      if (!lockIn)        armed <= 1'b0;
      else if (vsRise)    armed <= 1'b1;
      else if (newSample) armed <= 1'b0;
      if (startFrame)      frameOpen <= 1'b1;
      else if (closeFrame) frameOpen <= 1'b0;
      if (wrCtrl) begin
        runBit  <= regWrData[0];
        maskBit <= regWrData[1];
      end
      fmtFlag   <= (fmtFlag & ~(wrStat & regWrData[0])) | fmtChanged | lockRise | lockFall;
      truncFlag <= (truncFlag & ~(wrStat & regWrData[1])) | (frameOpen & lockFall);
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_CTRL: regRdData = REG_W'({maskBit, runBit});
      ADDR_STAT: regRdData = REG_W'({frameOpen, lockIn, fmtI, truncFlag, fmtFlag});
      ADDR_WID:  regRdData = REG_W'(fmtW);
      ADDR_HGT:  regRdData = REG_W'(fmtH);
    endcase
  end
endmodule

// File: rtl/vs_datapath.sv
module vs_datapath
  import vs_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] pixIn,
  output logic              strmValid,
  output logic              strmSop,
  output logic              strmEop,
  output logic [DATA_W-1:0] strmData
);
  logic [DATA_W-1:0] holdData;
  logic              holdSop;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdData <= '0; holdSop <= 1'b0;
      strmValid <= 1'b0; strmSop <= 1'b0; strmEop <= 1'b0; strmData <= '0;
    end else begin
      if (strobe.load) begin
        holdData <= pixIn;
        holdSop  <= strobe.loadSop;
      end
      strmValid <= strobe.emit;
      strmSop   <= strobe.emit & holdSop;
      strmEop   <= strobe.emit & strobe.emitEop;
      if (strobe.emit) strmData <= holdData;
    end
  end
endmodule

// File: rtl/sync_video_framer.sv
module sync_video_framer
  import vs_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lockIn,
  input  logic              activeIn,
  input  logic              hSyncIn,
  input  logic              vSyncIn,
  input  logic              fieldIn,
  input  logic [DATA_W-1:0] pixIn,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [1:0]        regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              strmValid,
  output logic              strmSop,
  output logic              strmEop,
  output logic [DATA_W-1:0] strmData,
  output logic              irq
);
  strobe_t          strobe;
  logic [CNT_W-1:0] fmtW, fmtH;
  logic             fmtI, fmtChanged, frameOpen, fmtFlag;

  vs_fmt #(.CNT_W(CNT_W)) u_fmt (
    .clk(clk), .rstN(rstN), .lockIn(lockIn), .activeIn(activeIn),
    .hSyncIn(hSyncIn), .vSyncIn(vSyncIn), .fieldIn(fieldIn),
    .pubW(fmtW), .pubH(fmtH), .pubI(fmtI), .changed(fmtChanged)
  );

  vs_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .lockIn(lockIn), .activeIn(activeIn), .vSyncIn(vSyncIn),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .fmtW(fmtW), .fmtH(fmtH), .fmtI(fmtI), .fmtChanged(fmtChanged),
    .strobe(strobe), .frameOpen(frameOpen), .fmtFlag(fmtFlag), .irq(irq)
  );

  vs_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pixIn(pixIn),
    .strmValid(strmValid), .strmSop(strmSop), .strmEop(strmEop), .strmData(strmData)
  );
endmodule

// File: rtl/vs_checker.sv
module vs_checker (
  input logic clk,
  input logic rstN,
  input logic lockIn,
  input logic strmValid,
  input logic strmSop,
  input logic strmEop,
  input logic frameOpen,
  input logic fmtFlag
);
  AST_SOP_HAS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    strmSop |-> strmValid); // R5
  AST_EOP_HAS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    strmEop |-> strmValid); // R5
  AST_MID_PACKET_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (strmValid && !strmEop) |-> frameOpen); // R5
  AST_QUIET_UNLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (!lockIn && $past(!lockIn)) |=> !strmValid); // R6
  AST_LOCK_LOSS_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(lockIn) && frameOpen) |=> (strmValid && strmEop)); // R7
  AST_LOCK_EDGE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(lockIn) || $fell(lockIn)) |=> fmtFlag); // R9
endmodule

bind sync_video_framer vs_checker u_chk (
  .clk(clk), .rstN(rstN), .lockIn(lockIn), .strmValid(strmValid),
  .strmSop(strmSop), .strmEop(strmEop), .frameOpen(frameOpen), .fmtFlag(fmtFlag)
);

// File: tb/sim_sync_video_framer.sv
module sim_sync_video_framer;
  logic clk = 1'b0, rstN = 1'b0;
  logic lockIn = 1'b0, activeIn = 1'b0, hSyncIn = 1'b0, vSyncIn = 1'b0, fieldIn = 1'b0;
  logic [7:0]  pixIn = '0;
  logic [1:0]  regAddr = '0, regWrData = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regRdData;
  logic        strmValid, strmSop, strmEop, irq;
  logic [7:0]  strmData;

  int errors = 0, checks = 0, pixSeq = 0, cycleCnt = 0;
  int outCnt = 0, sopCnt = 0, eopCnt = 0, curLen = 0, lastLen = 0, orderErr = 0, eopCycle = 0;
  logic [7:0] lastData = '0;
  logic maskBit = 1'b0;

  sync_video_framer #(.DATA_W(8), .CNT_W(8)) u0 (
    .clk(clk), .rstN(rstN), .lockIn(lockIn), .activeIn(activeIn), .hSyncIn(hSyncIn),
    .vSyncIn(vSyncIn), .fieldIn(fieldIn), .pixIn(pixIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .strmValid(strmValid), .strmSop(strmSop), .strmEop(strmEop), .strmData(strmData), .irq(irq)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  always @(negedge clk) begin
    if (rstN && strmValid) begin
      if (strmSop) curLen = 1;
      else begin
        curLen++;
        if (strmData !== lastData + 8'd1) orderErr++;
      end
      lastData = strmData;
      outCnt++;
      if (strmSop) sopCnt++;
      if (strmEop) begin eopCnt++; lastLen = curLen; eopCycle = cycleCnt; end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    cyc();
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    regAddr = a; #1;
    v = int'(regRdData);
  endtask

  task automatic vsyncPulse(input logic fld);
    fieldIn = fld; activeIn = 1'b0; vSyncIn = 1'b1;
    repeat (3) cyc();
    vSyncIn = 1'b0;
    repeat (2) cyc();
  endtask

  task automatic sendField(input int w, input int h, input logic fld, input int enLine, input int disLine);
    vsyncPulse(fld);
    for (int l = 0; l < h; l++) begin
      if (l == enLine)  wr(2'd0, {maskBit, 1'b1});
      if (l == disLine) wr(2'd0, {maskBit, 1'b0});
      hSyncIn = 1'b1; repeat (2) cyc();
      hSyncIn = 1'b0; cyc();
      for (int s = 0; s < w; s++) begin
        activeIn = 1'b1; pixIn = 8'(pixSeq); pixSeq++;
        cyc();
      end
      activeIn = 1'b0; cyc();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v, s0, e0, o0, dropCycle;
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();
    // R1: reset state
    check(strmValid == 1'b0 && irq == 1'b0, "R1 outputs idle", int'(strmValid) + int'(irq), 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check(v == 0, "R1 register zero", v, 0);
    end

    // R2, R8, R9: lock up with output off
    lockIn = 1'b1; cyc();
    rd(2'd1, v); check(v[0] == 1'b1, "R9 lock rise flag", v[0], 1);
    check(irq == 1'b0, "R9 irq masked", int'(irq), 0);
    repeat (3) sendField(4, 3, 1'b0, -1, -1);
    vsyncPulse(1'b0);
    check(outCnt == 0, "R2 no output while off", outCnt, 0);
    rd(2'd2, v); check(v == 4, "R2 R8 width measured while off", v, 4);
    rd(2'd3, v); check(v == 3, "R2 R8 height measured while off", v, 3);
    maskBit = 1'b1; wr(2'd0, 2'b10);
    check(irq == 1'b1, "R9 irq unmasked", int'(irq), 1);
    wr(2'd1, 2'b01);
    check(irq == 1'b0, "R9 write-one clears flag", int'(irq), 0);
    rd(2'd1, v); check(v[0] == 1'b0, "R9 flag cleared", v[0], 0);

    // R3: run set mid-field waits for the next field
    s0 = sopCnt; e0 = eopCnt;
    sendField(4, 3, 1'b0, 1, -1);
    sendField(4, 3, 1'b0, -1, -1);
    vsyncPulse(1'b0);
    check(sopCnt - s0 == 1, "R3 one packet only", sopCnt - s0, 1);
    check(eopCnt - e0 == 1, "R3 one packet end", eopCnt - e0, 1);
    check(lastLen == 12, "R3 full packet length", lastLen, 12);

    // R5, R8: shape sweep with output on
    for (int w = 1; w <= 4; w++) begin
      for (int h = 1; h <= 3; h++) begin
        s0 = sopCnt; e0 = eopCnt;
        repeat (3) sendField(w, h, 1'b0, -1, -1);
        vsyncPulse(1'b0);
        check(sopCnt - s0 == 3, "R5 start markers", sopCnt - s0, 3);
        check(eopCnt - e0 == 3, "R5 end markers", eopCnt - e0, 3);
        check(lastLen == w * h, "R5 packet length", lastLen, w * h);
        rd(2'd2, v); check(v == w, "R8 width", v, w);
        rd(2'd3, v); check(v == h, "R8 height", v, h);
        rd(2'd1, v); check(v[0] == 1'b1, "R9 change flag on new shape", v[0], 1);
        wr(2'd1, 2'b01);
      end
    end

    // R4: run cleared mid-packet
    s0 = sopCnt; e0 = eopCnt;
    sendField(3, 2, 1'b0, -1, 1);
    sendField(3, 2, 1'b0, -1, -1);
    vsyncPulse(1'b0);
    check(sopCnt - s0 == 1, "R4 packet finishes then stops", sopCnt - s0, 1);
    check(eopCnt - e0 == 1, "R4 single end marker", eopCnt - e0, 1);
    check(lastLen == 6, "R4 full length kept", lastLen, 6);

    // R7: lock lost mid-line
    wr(2'd0, 2'b11);
    wr(2'd1, 2'b01);
    e0 = eopCnt;
    vsyncPulse(1'b0);
    hSyncIn = 1'b1; repeat (2) cyc();
    hSyncIn = 1'b0; cyc();
    for (int s = 0; s < 5; s++) begin
      activeIn = 1'b1; pixIn = 8'(pixSeq); pixSeq++; cyc();
    end
    lockIn = 1'b0; dropCycle = cycleCnt;
    repeat (3) cyc();
    check(eopCnt - e0 == 1, "R7 packet closed", eopCnt - e0, 1);
    check(lastLen == 5, "R7 truncated length", lastLen, 5);
    check(eopCycle == dropCycle + 1, "R7 end marker timing", eopCycle, dropCycle + 1);
    rd(2'd1, v); check(v[1] == 1'b1, "R7 truncated flag", v[1], 1);
    check(v[0] == 1'b1, "R9 lock fall flag", v[0], 1);

    // R6: unlocked traffic is ignored
    o0 = outCnt;
    sendField(7, 2, 1'b1, -1, -1);
    sendField(7, 2, 1'b1, -1, -1);
    vsyncPulse(1'b1);
    check(outCnt == o0, "R6 no output unlocked", outCnt, o0);
    rd(2'd2, v); check(v == 3, "R6 width held", v, 3);
    rd(2'd3, v); check(v == 2, "R6 height held", v, 2);
    rd(2'd1, v); check(v[2] == 1'b0 && v[3] == 1'b0, "R6 R10 status while unlocked", v[3:2], 0);
    wr(2'd1, 2'b10);
    rd(2'd1, v); check(v[1] == 1'b0, "R7 truncated flag cleared", v[1], 0);
    wr(2'd1, 2'b01);
    lockIn = 1'b1; cyc();
    rd(2'd1, v); check(v[0] == 1'b1 && v[3] == 1'b1, "R9 R10 relock flag and lock bit", v[3:0], 9);

    // R10: interlace detection and return to progressive
    wr(2'd0, 2'b10);
    for (int f = 0; f < 4; f++) sendField(3, 2, 1'(f % 2), -1, -1);
    rd(2'd1, v); check(v[2] == 1'b1, "R10 interlace detected", v[2], 1);
    repeat (3) sendField(3, 2, 1'b0, -1, -1);
    vsyncPulse(1'b0);
    rd(2'd1, v); check(v[2] == 1'b0, "R10 progressive again", v[2], 0);
    check(orderErr == 0, "R5 sample order", orderErr, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule